// File: doc/BRIEF.md
# Power-on Reset and Clock-Source Sequencer

This block orders the events that follow a power-on reset on a chip that can be clocked in two ways. The first is a main oscillator multiplied up by a PLL. The second is a slow on-chip backup clock, used in limp mode. The block samples a limp-enable strap while power-on reset is active. It waits for the oscillator as needed, times the PLL lock with a behavioural counter, holds the chip's hard reset for a fixed window, and drives the clock-source select.

When limp mode is strapped on and the oscillator is not yet valid at reset release, the chip leaves reset on the backup clock. Once the PLL has locked, software can move the chip to the PLL. When limp mode is strapped off, the backup clock is never selected, and the chip stays in hard reset until the oscillator is valid, the PLL has locked and the hold window has passed. The analog PLL, the oscillator and the glitch-free clock multiplexer sit outside this block.

Top module: `rcs_seq`

## Requirements
- R1: While `por` is high, `hard_reset` is 1, `pll_locked` is 0 and `clk_sel` is 0 (PLL).
- R2: The limp-enable value is taken from `limp_strap` while `por` is high. Changes on `limp_strap` after `por` falls have no effect until the next power-on reset.
- R3: If limp is enabled and the synchronized oscillator-valid flag is 0 on the first clock edge after `por` falls, that edge sets `clk_sel` to 1 (backup). The status limp bit is then 1. Status layout: bit 0 = clock source (1 backup), bit 1 = lock, bit 2 = limp mode, bit 3 = hard reset.
- R4: With limp disabled, `clk_sel` stays 0, and lock counting starts only on the edge after the synchronized oscillator-valid flag is first seen high. `osc_valid` passes through two flops, so that start edge is the third edge after `osc_valid` rises.
- R5: With `mf` <= 4 at the start of counting, `pll_locked` rises 500 clock edges after the counting start edge.
- R6: With `mf` > 4, `pll_locked` rises 1000 edges after the counting start edge.
- R7: With the chip not in limp mode, `hard_reset` falls exactly 512 edges after the edge on which `pll_locked` rises.
- R8: In limp mode, `hard_reset` falls 512 edges after the edge that selected the backup clock.
- R9: In limp mode with `pll_locked` = 1, a request on `sw_switch_req` sets `clk_sel` to 0 and clears the limp bit on the third edge after the request rises, because the request passes through two flops.
- R10: A switch request made before lock, or made when the chip is not in limp mode, leaves `clk_sel` unchanged.
- R11: `div_high` and `div_low` read 0 after power-on reset. A value of 0 means divide by 1 for the high field and divide by 2 for the low field.
- R12: Every new assertion of `por` restarts the whole sequence, whatever state the block was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference/system clock |
| por | input | 1 | Power-on reset, active high |
| limp_strap | input | 1 | Limp-enable strap, sampled during `por` |
| osc_valid | input | 1 | Asynchronous oscillator-valid flag |
| mf | input | MF_W | PLL multiplication-factor field |
| sw_switch_req | input | 1 | Asynchronous software request to move to the PLL |
| clk_sel | output | 1 | Clock source select: 0 PLL, 1 backup |
| pll_locked | output | 1 | Behavioural PLL lock flag |
| hard_reset | output | 1 | Chip hard reset, active high |
| status | output | 4 | {hard reset, limp, lock, source} |
| div_high | output | DIV_W | High-frequency divider reset value |
| div_low | output | DIV_W | Low-frequency divider reset value |

## Verification
Several rules are checked by assertions on every cycle. Hard reset holds while `por` is high. The backup clock never appears when limp is strapped off. Lock never comes before the oscillator is seen, and lock stays set once reached. Hard reset is released only after lock or in limp mode. The move to the PLL happens only after lock and is never undone. The exact lock and release cycle counts, the effect of the multiplication factor on the lock time, the strap being held, the switch latency and the restart on a second power-on reset can only be shown by the bench's scenarios. Those scenarios compare measured edge numbers against values computed from the requirements.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic {
    SRC_PLL    = 1'b0,
    SRC_BACKUP = 1'b1
  } clk_src_e;

  localparam int STAT_W    = 4;
  localparam int STAT_SRC  = 0;
  localparam int STAT_LOCK = 1;
  localparam int STAT_LIMP = 2;
  localparam int STAT_HRST = 3;
endpackage

// File: rtl/rcs_sync.sv
// Two-flop synchronizer, one chain per bit.
module rcs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta, stable;
    always_ff @(posedge clk) begin
      meta   <= d[b];
      stable <= meta;
    end
    assign q[b] = stable;
  end
endmodule

// File: rtl/rcs_timer.sv
// Counts run cycles; done rises on the len-th edge with run high, then sticks.
module rcs_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (run && !done) begin
      if (cnt == len - CNT_W'(1)) done <= 1'b1;
      else                        cnt  <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rcs_seq.sv
module rcs_seq #(
  parameter int MF_W       = 12,
  parameter int MF_LIMIT   = 4,
  parameter int LOCK_SHORT = 500,
  parameter int LOCK_LONG  = 1000,
  parameter int HOLD_CYC   = 512,
  parameter int DIV_W      = 3
) (
  input  logic                      clk,
  input  logic                      por,
  input  logic                      limp_strap,
  input  logic                      osc_valid,
  input  logic [MF_W-1:0]           mf,
  input  logic                      sw_switch_req,
  output logic                      clk_sel,
  output logic                      pll_locked,
  output logic                      hard_reset,
  output logic [rcs_pkg::STAT_W-1:0] status,
  output logic [DIV_W-1:0]          div_high,
  output logic [DIV_W-1:0]          div_low
);
  import rcs_pkg::*;

  localparam int LOCK_W = $clog2(LOCK_LONG + 1);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [LOCK_W-1:0] LEN_SHORT = LOCK_W'(LOCK_SHORT);
  localparam logic [LOCK_W-1:0] LEN_LONG  = LOCK_W'(LOCK_LONG);
  localparam logic [HOLD_W-1:0] LEN_HOLD  = HOLD_W'(HOLD_CYC);

  logic [1:0] async_in, synced;
  logic       osc_s, sw_s;
  logic       limp_en;      // strap value captured during power-on reset
  logic       decided;      // first post-reset edge has chosen the source
  clk_src_e   src_q;
  logic       osc_ok;       // oscillator seen, PLL locking under way
  logic       long_q;       // long lock window selected
  logic       lock_done, hold_done;

  assign async_in = {sw_switch_req, osc_valid};

  rcs_sync #(.W(2)) i_sync (
    .clk (clk),
    .d   (async_in),
    .q   (synced)
  );
  assign osc_s = synced[0];
  assign sw_s  = synced[1];

  always_ff @(posedge clk) begin
    if (por) limp_en <= limp_strap;
  end

  always_ff @(posedge clk) begin
    if (por) begin
      decided <= 1'b0;
      src_q   <= SRC_PLL;
      osc_ok  <= 1'b0;
      long_q  <= 1'b0;
    end else begin
      if (!decided) begin
        decided <= 1'b1;
        if (limp_en && !osc_s) src_q <= SRC_BACKUP;
      end else if (src_q == SRC_BACKUP && lock_done && sw_s) begin
        src_q <= SRC_PLL;
      end
      if (!osc_ok && osc_s) begin
        osc_ok <= 1'b1;
        long_q <= (mf > MF_W'(MF_LIMIT));
      end
    end
  end

  rcs_timer #(.CNT_W(LOCK_W)) i_lock (
    .clk  (clk),
    .clr  (por),
    .run  (osc_ok),
    .len  (long_q ? LEN_LONG : LEN_SHORT),
    .done (lock_done)
  );

  rcs_timer #(.CNT_W(HOLD_W)) i_hold (
    .clk  (clk),
    .clr  (por),
    .run  (lock_done || src_q == SRC_BACKUP),
    .len  (LEN_HOLD),
    .done (hold_done)
  );

  assign clk_sel    = (src_q == SRC_BACKUP);
  assign pll_locked = lock_done;
  assign hard_reset = por || !hold_done;

  always_comb begin
    status            = '0;
    status[STAT_SRC]  = clk_sel;
    status[STAT_LOCK] = pll_locked;
    status[STAT_LIMP] = clk_sel;
    status[STAT_HRST] = hard_reset;
  end

  // Divider fields come out of power-on reset at their reset codes.
  assign div_high = '0;
  assign div_low  = '0;
endmodule

// File: rtl/rcs_seq_chk.sv
module rcs_seq_chk (
  input logic clk,
  input logic por,
  input logic limp_en,
  input logic osc_ok,
  input logic clk_sel,
  input logic pll_locked,
  input logic hard_reset
);
  // R1
  p_hreset_in_por_r1: assert property (@(posedge clk) por |-> hard_reset);

  // R4
  p_no_backup_r4: assert property (@(posedge clk) disable iff (por)
    !limp_en |-> !clk_sel);

  // R4
  p_lock_after_osc_r4: assert property (@(posedge clk) disable iff (por)
    pll_locked |-> osc_ok);

  // R5
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (por)
    pll_locked |=> pll_locked);

  // R7
  p_release_gated_r7: assert property (@(posedge clk) disable iff (por)
    $fell(hard_reset) |-> (pll_locked || clk_sel));

  // R9
  p_switch_needs_lock_r9: assert property (@(posedge clk) disable iff (por)
    $fell(clk_sel) |-> pll_locked);

  // R10
  p_no_return_r10: assert property (@(posedge clk) disable iff (por)
    (pll_locked && !clk_sel) |=> !clk_sel);
endmodule

bind rcs_seq rcs_seq_chk i_chk (
  .clk        (clk),
  .por        (por),
  .limp_en    (limp_en),
  .osc_ok     (osc_ok),
  .clk_sel    (clk_sel),
  .pll_locked (pll_locked),
  .hard_reset (hard_reset)
);

// File: tb/test_rcs_seq.sv
module test_rcs_seq;
  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        limp_strap = 1'b0;
  logic        osc_valid = 1'b0;
  logic [11:0] mf = '0;
  logic        sw_req = 1'b0;
  logic        clk_sel, pll_locked, hard_reset;
  logic [3:0]  status;
  logic [2:0]  div_high, div_low;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rcs_seq i_rcs_seq (
    .clk           (clk),
    .por           (por),
    .limp_strap    (limp_strap),
    .osc_valid     (osc_valid),
    .mf            (mf),
    .sw_switch_req (sw_req),
    .clk_sel       (clk_sel),
    .pll_locked    (pll_locked),
    .hard_reset    (hard_reset),
    .status        (status),
    .div_high      (div_high),
    .div_low       (div_low)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  function automatic bit exp_limp(input bit strap, input bit early);
    return strap && !early;
  endfunction

  function automatic int exp_lock(input int r, input bit early, input int d,
                                  input logic [11:0] m);
    int n;
    n = (m > 12'd4) ? 1000 : 500;
    return early ? r + 1 + n : r + d + 3 + n;
  endfunction

  task automatic run_case(input bit strap, input logic [11:0] mfv,
                          input bit early, input int d);
    int r, lk, rel, s, lk_exp;
    bit lx;
    @(negedge clk);
    por = 1'b1; limp_strap = strap; mf = mfv; osc_valid = early; sw_req = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 R12 hard_reset during por", hard_reset, 1);
    chk("R1 R12 lock cleared during por", pll_locked, 0);
    chk("R1 clk_sel during por", clk_sel, 0);
    chk("R11 div_high reset code", div_high, 0);
    chk("R11 div_low reset code", div_low, 0);

    por = 1'b0; r = cyc; limp_strap = ~strap;   // R2: late strap change ignored
    lx = exp_limp(strap, early);
    wait_cyc(r + 1);
    chk("R2 R3 limp flag", status[2], lx);
    chk("R3 clock select", clk_sel, lx);
    if (!strap) chk("R4 backup unused", clk_sel, 0);
    if (!early) begin wait_cyc(r + d); osc_valid = 1'b1; end

    wait_cyc(r + 20); sw_req = 1'b1;
    wait_cyc(r + 23); sw_req = 1'b0;
    wait_cyc(r + 30);
    chk("R10 request before lock ignored", clk_sel, lx);

    lk = -1; rel = -1;
    while ((lk < 0 || rel < 0) && cyc < r + 3000) begin
      @(negedge clk);
      if (lk < 0 && pll_locked)  lk = cyc;
      if (rel < 0 && !hard_reset) rel = cyc;
    end
    lk_exp = exp_lock(r, early, d, mfv);
    if (mfv > 12'd4) chk("R6 long lock time", lk, lk_exp);
    else             chk("R5 short lock time", lk, lk_exp);
    if (lx) chk("R8 limp reset release", rel, r + 513);
    else    chk("R7 reset release after lock", rel, lk_exp + 512);
    chk("R3 status word", status, {1'b0, lx, 1'b1, lx});

    s = cyc; sw_req = 1'b1;
    wait_cyc(s + 2);
    chk("R9 select before sync done", clk_sel, lx);
    wait_cyc(s + 3);
    if (lx) begin
      chk("R9 switched to pll", clk_sel, 0);
      chk("R9 limp flag cleared", status[2], 0);
    end else begin
      wait_cyc(s + 6);
      chk("R10 request outside limp ignored", clk_sel, 0);
    end
    sw_req = 1'b0;
    wait_cyc(s + 8);
  endtask

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd1234);
    // directed corners
    run_case(1'b1, 12'd4,    1'b0, 5);
    run_case(1'b1, 12'd5,    1'b0, 9);
    run_case(1'b0, 12'd0,    1'b0, 12);
    run_case(1'b0, 12'd4095, 1'b1, 0);
    run_case(1'b1, 12'd4,    1'b1, 0);
    // constrained random
    for (int i = 0; i < 7; i++) begin
      bit st, ea;
      logic [11:0] m;
      int dd;
      st = 1'($urandom % 2);
      ea = 1'($urandom % 2);
      m  = ($urandom % 2 == 0) ? 12'($urandom % 8) : 12'($urandom % 4096);
      dd = 1 + int'($urandom % 15);
      run_case(st, m, ea, dd);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule